// File: doc/BRIEF.md
# Per-Slave Bus Matrix Arbiter

This block arbitrates access to one slave port of a multi-master bus matrix. Every slave port carries its own copy, so the choice for one slave never depends on traffic to another. Each master raises a request line. The master that currently owns the slave describes its transfer on a shared set of phase inputs: active or idle, first or following beat, and burst kind with length. The block drives a one-hot grant and the index of the connected master. It also drives a flag that shows when a parked default master is served with no lost cycle.

Configuration inputs choose the arbitration type, either rotating (round-robin) or fixed priority with one priority field per master. They also set the idle policy: release the slave, stay on the last master, or park on a chosen master. A slot limit can cut off long transfers. The grant can move only at an arbitration point. A master that finds the slave parked on itself proceeds at once. Any other master waits one cycle, because the new grant is registered.

Top module: `bus_slave_arbiter`

## Requirements
- R1: `gnt` always has at most one bit set. `gnt_idx` equals the position of that bit, and is 0 when `gnt` is zero.
- R2: While `rst_n` is low and on the first cycle after reset, `gnt` is zero and `def_hit` is low.
- R3: An arbitration point is any cycle in which one of these holds: no master is connected; `xfer_act` is low; the kind is single (`xfer_kind` 00 or 11); it is the last beat of a defined burst; or the slot limit is reached. In every other cycle the next `gnt` equals the current one.
- R4: A defined burst (`xfer_kind` 10) gets its length from `xfer_len` on its first beat (`xfer_seq` 0). The grant may move after exactly that many active beats. A length of 0 or 1 ends on the first beat, and `xfer_len` is ignored on following beats.
- R5: An undefined-length burst (`xfer_kind` 01) keeps the grant until its master drops `xfer_act` or the slot limit is reached.
- R6: If `cfg_slot_lim` = L is nonzero, an active access that has no other arbitration point reaches one after L active cycles. The count restarts at every arbitration point. L = 0 turns this off.
- R7: With `cfg_fixed_pri` low, the winner is the first requesting master found by searching upward, with wraparound, from the master after the most recent owner.
- R8: With `cfg_fixed_pri` high, the winner is the requester with the largest field in `cfg_prio` (master i uses bits i*PW+:PW). On a tie, the lowest index wins.
- R9: With `cfg_def_mode` 00 or 11, an arbitration point that has no request clears `gnt`.
- R10: With `cfg_def_mode` 01, an arbitration point that has no request leaves `gnt` unchanged.
- R11: With `cfg_def_mode` 10, an arbitration point that has no request parks the grant on `cfg_def_idx` in the next cycle. A different master that then requests receives the grant one cycle after its request.
- R12: `def_hit` is high in a cycle only if the grant was last set with no request pending and the connected master is now requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | N | Request line from each master |
| xfer_act | input | 1 | Connected master is accessing this cycle |
| xfer_seq | input | 1 | 1 = following beat of a burst, 0 = first beat or single access |
| xfer_kind | input | 2 | 00/11 single, 01 undefined-length burst, 10 defined burst |
| xfer_len | input | LW | Beat count of a defined burst, read on its first beat |
| cfg_fixed_pri | input | 1 | 0 = round-robin, 1 = fixed priority |
| cfg_prio | input | N*PW | Priority field for each master |
| cfg_def_mode | input | 2 | 00 none, 01 last owner, 10 fixed master, 11 none |
| cfg_def_idx | input | IW | Master to park on in fixed mode |
| cfg_slot_lim | input | SW | Slot cycle limit, 0 = off |
| gnt | output | N | One-hot grant |
| gnt_idx | output | IW | Index of the granted master |
| def_hit | output | 1 | Parked master is requesting with no lost cycle |

## Verification
The assertions assume that the phase inputs describe only the connected master. They also assume that `xfer_act` is high only while that master keeps its request up, and that a following beat only continues a burst that the same owner started. Configuration is assumed to change only while every request is low. The bench generates transfers from its own record of who owns the slave. It raises `xfer_act` only for that owner and continues bursts only for the master that began them. It changes configuration only after several idle cycles. Random phases mix request rates and burst shapes across both arbitration types and all idle policies. Directed sequences cover defined bursts, long undefined bursts, slot breaks, and parking.

// File: rtl/bus_slave_arbiter.sv
module bus_slave_arbiter #(
  parameter int N  = 4,
  parameter int PW = 2,
  parameter int LW = 4,
  parameter int SW = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  input  logic            xfer_act,
  input  logic            xfer_seq,
  input  logic [1:0]      xfer_kind,
  input  logic [LW-1:0]   xfer_len,
  input  logic            cfg_fixed_pri,
  input  logic [N*PW-1:0] cfg_prio,
  input  logic [1:0]      cfg_def_mode,
  input  logic [IW-1:0]   cfg_def_idx,
  input  logic [SW-1:0]   cfg_slot_lim,
  output logic [N-1:0]    gnt,
  output logic [IW-1:0]   gnt_idx,
  output logic            def_hit
);

  logic [N-1:0]  gnt_q;
  logic [IW-1:0] last_q;
  logic          parked_q;
  logic [LW-1:0] beats_q;
  logic [SW-1:0] slot_q;

  wire connected = |gnt_q;
  wire busy      = connected & xfer_act;
  wire k_undef   = (xfer_kind == 2'b01);
  wire k_def     = (xfer_kind == 2'b10);
  wire k_single  = !k_undef && !k_def;
  wire def_last  = k_def && (xfer_seq ? (beats_q == LW'(1)) : (xfer_len <= LW'(1)));
  wire slot_hit  = (cfg_slot_lim != '0) && (slot_q >= cfg_slot_lim - SW'(1));
  wire arb_ok    = !busy || k_single || def_last || slot_hit;
  wire any_req   = |req;

  logic [IW-1:0] rr_idx, fp_idx, win_idx;
  logic          rr_found, fp_found;
  logic [PW-1:0] fp_best;

  always_comb begin
    rr_idx = '0;
    rr_found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(last_q) + k) % N;
      if (!rr_found && req[j]) begin
        rr_found = 1'b1;
        rr_idx = IW'(j);
      end
    end
  end

  always_comb begin
    fp_idx = '0;
    fp_best = '0;
    fp_found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!fp_found || cfg_prio[i*PW +: PW] > fp_best)) begin
        fp_found = 1'b1;
        fp_best = cfg_prio[i*PW +: PW];
        fp_idx = IW'(i);
      end
    end
  end

  assign win_idx = cfg_fixed_pri ? fp_idx : rr_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q    <= '0;
      last_q   <= '0;
      parked_q <= 1'b0;
      beats_q  <= '0;
      slot_q   <= '0;
    end else begin
      if (busy && k_def)
        beats_q <= xfer_seq ? beats_q - LW'(1) : xfer_len - LW'(1);
      if (arb_ok)
        slot_q <= '0;
      else if (slot_q != '1)
        slot_q <= slot_q + SW'(1);
      if (arb_ok) begin
        if (any_req) begin
          gnt_q    <= N'(1) << win_idx;
          last_q   <= win_idx;
          parked_q <= 1'b0;
        end else begin
          case (cfg_def_mode)
            2'b01: parked_q <= connected;
            2'b10: begin
              gnt_q    <= N'(1) << cfg_def_idx;
              last_q   <= cfg_def_idx;
              parked_q <= 1'b1;
            end
            default: begin
              gnt_q    <= '0;
              parked_q <= 1'b0;
            end
          endcase
        end
      end
    end
  end

  always_comb begin
    gnt_idx = '0;
    for (int i = 0; i < N; i++)
      if (gnt_q[i]) gnt_idx = IW'(i);
  end

  assign gnt     = gnt_q;
  assign def_hit = parked_q && |(req & gnt_q);

  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_undef_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) && xfer_act && (xfer_kind == 2'b01) && (cfg_slot_lim == '0) |=> $stable(gnt));

  assert_none_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_def_mode == 2'b00) || (cfg_def_mode == 2'b11)) && (req == '0) |=> (gnt == '0));

  assert_fixed_park_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_def_mode == 2'b10) && (req == '0) |=> (gnt == (N'(1) << $past(cfg_def_idx))));

  assert_single_rotate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) && xfer_act && (xfer_kind == 2'b00) && !cfg_fixed_pri && ((req & ~gnt) != '0)
    |=> (gnt != $past(gnt)));

endmodule

// File: tb/bus_slave_arbiter_bench.sv
`timescale 1ns/1ps
module bus_slave_arbiter_bench;
  localparam int N = 4, PW = 2, LW = 4, SW = 6, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] d_req = '0;
  logic d_act = 0, d_seq = 0;
  logic [1:0] d_kind = '0;
  logic [LW-1:0] d_len = '0;
  logic c_fp = 0;
  logic [N*PW-1:0] c_prio = '0;
  logic [1:0] c_mode = '0;
  logic [IW-1:0] c_idx = '0;
  logic [SW-1:0] c_lim = '0;
  logic [N-1:0] gnt;
  logic [IW-1:0] gnt_idx;
  logic def_hit;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_own = -1, m_last = 0, m_beats = 0, m_slot = 0;
  bit m_parked = 0;
  int bs = 0, bs_left = 0, req_pct = 40;

  always #2.5 clk = ~clk;

  bus_slave_arbiter #(.N(N), .PW(PW), .LW(LW), .SW(SW)) u_bus_slave_arbiter (
    .clk(clk), .rst_n(rst_n), .req(d_req), .xfer_act(d_act), .xfer_seq(d_seq),
    .xfer_kind(d_kind), .xfer_len(d_len), .cfg_fixed_pri(c_fp), .cfg_prio(c_prio),
    .cfg_def_mode(c_mode), .cfg_def_idx(c_idx), .cfg_slot_lim(c_lim),
    .gnt(gnt), .gnt_idx(gnt_idx), .def_hit(def_hit));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rr_pick(logic [N-1:0] r, int last);
    for (int k = 1; k <= N; k++) if (r[(last + k) % N]) return (last + k) % N;
    return 0;
  endfunction

  function automatic int fp_pick(logic [N-1:0] r, logic [N*PW-1:0] p);
    int best = -1, bi = 0;
    for (int i = 0; i < N; i++)
      if (r[i] && int'(p[i*PW +: PW]) > best) begin best = int'(p[i*PW +: PW]); bi = i; end
    return bi;
  endfunction

  task automatic cyc(string tag);
    bit busy, single, dlast, shit, arb;
    int lim, own_n, last_n, beats_n, slot_n;
    bit park_n;
    #1;
    chk({tag, " R12 def_hit"}, def_hit, (m_parked && m_own >= 0 && d_req[m_own]) ? 1 : 0);
    lim = int'(c_lim);
    busy = (m_own >= 0) && d_act;
    single = !(d_kind == 2'b01 || d_kind == 2'b10);
    dlast = (d_kind == 2'b10) && (d_seq ? (m_beats == 1) : (int'(d_len) <= 1));
    shit = (lim != 0) && (m_slot >= lim - 1);
    arb = !busy || single || dlast || shit;
    own_n = m_own; last_n = m_last; park_n = m_parked; beats_n = m_beats;
    if (busy && d_kind == 2'b10) beats_n = d_seq ? ((m_beats - 1) & 15) : ((int'(d_len) - 1) & 15);
    slot_n = arb ? 0 : (m_slot == 63 ? 63 : m_slot + 1);
    if (arb) begin
      if (d_req != '0) begin
        own_n = c_fp ? fp_pick(d_req, c_prio) : rr_pick(d_req, m_last);
        last_n = own_n; park_n = 0;
      end else if (c_mode == 2'b01) park_n = (m_own >= 0);
      else if (c_mode == 2'b10) begin own_n = int'(c_idx); last_n = own_n; park_n = 1; end
      else begin own_n = -1; park_n = 0; end
    end
    @(negedge clk);
    m_own = own_n; m_last = last_n; m_parked = park_n; m_beats = beats_n; m_slot = slot_n;
    chk({tag, " grant"}, int'(gnt), m_own >= 0 ? (1 << m_own) : 0);
    chk("R1 index", int'(gnt_idx), m_own >= 0 ? m_own : 0);
    chk("R1 onehot", $countones(gnt) <= 1, 1);
  endtask

  task automatic drive(logic [N-1:0] r, bit a, bit s, logic [1:0] k, int len);
    d_req = r; d_act = a; d_seq = s; d_kind = k; d_len = LW'(len);
  endtask

  task automatic idle(int n);
    drive('0, 0, 0, 0, 0);
    for (int i = 0; i < n; i++) cyc("idle");
    bs = 0;
  endtask

  task automatic gen();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = ($urandom % 100) < req_pct;
    d_act = 0; d_seq = 0; d_kind = 0; d_len = LW'($urandom);
    if (m_own >= 0) begin
      if (bs == 1) begin
        if ($urandom % 6 == 0) bs = 0;
        else begin r[m_own] = 1; d_act = 1; d_seq = 1; d_kind = 2'b01; end
      end else if (bs == 2) begin
        r[m_own] = 1; d_act = 1; d_seq = 1; d_kind = 2'b10;
        bs_left--; if (bs_left == 0) bs = 0;
      end else if (r[m_own] && $urandom % 4 != 0) begin
        d_act = 1;
        case ($urandom % 3)
          0: d_kind = ($urandom % 2) ? 2'b00 : 2'b11;
          1: begin d_kind = 2'b01; bs = 1; end
          default: begin
            d_kind = 2'b10; bs_left = 1 + $urandom % 5; d_len = LW'(bs_left);
            bs_left--; bs = (bs_left != 0) ? 2 : 0;
          end
        endcase
      end
    end
    d_req = r;
  endtask

  task automatic rand_phase(string tag, int n);
    for (int i = 0; i < n; i++) begin
      int prev;
      prev = m_own;
      gen();
      cyc(tag);
      if (m_own != prev) bs = 0;
    end
    idle(3);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R2 reset gnt", int'(gnt), 0);
    chk("R2 reset def_hit", def_hit, 0);
    rst_n = 1'b1;
    #1 chk("R2 first cycle gnt", int'(gnt), 0);
    idle(2);

    drive(4'b0010, 0, 0, 0, 0); cyc("R7 first grant");
    drive(4'b0110, 1, 0, 2'b10, 4); cyc("R4 beat1");
    drive(4'b0110, 1, 1, 2'b10, 9); cyc("R4 beat2");
    drive(4'b0110, 1, 1, 2'b10, 0); cyc("R4 beat3");
    chk("R3 held mid burst", int'(gnt), 4'b0010);
    drive(4'b0110, 1, 1, 2'b10, 3); cyc("R4 beat4");
    chk("R3 moved after last beat", int'(gnt), 4'b0100);
    idle(2);

    drive(4'b0001, 0, 0, 0, 0); cyc("R7 wrap");
    drive(4'b1001, 1, 0, 2'b01, 0); cyc("R5 start");
    for (int i = 0; i < 8; i++) begin drive(4'b1001, 1, 1, 2'b01, i); cyc("R5 hold"); end
    chk("R5 still held", int'(gnt), 4'b0001);
    drive(4'b1001, 0, 0, 0, 0); cyc("R5 release");
    chk("R5 moved after idle", int'(gnt), 4'b1000);
    idle(2);

    c_lim = 6'd3;
    drive(4'b0001, 0, 0, 0, 0); cyc("R6 grant");
    drive(4'b0101, 1, 0, 2'b01, 0); cyc("R6 beat");
    drive(4'b0101, 1, 1, 2'b01, 0); cyc("R6 beat");
    chk("R6 held before limit", int'(gnt), 4'b0001);
    drive(4'b0101, 1, 1, 2'b01, 0); cyc("R6 beat");
    chk("R6 broken at limit", int'(gnt), 4'b0100);
    idle(2); c_lim = '0;

    c_mode = 2'b10; c_idx = 2'd2;
    idle(2);
    chk("R11 parked", int'(gnt), 4'b0100);
    drive(4'b0100, 1, 0, 2'b00, 0); cyc("R12 parked request");
    drive('0, 0, 0, 0, 0); cyc("R11 idle");
    drive(4'b0010, 0, 0, 0, 0);
    #1 chk("R11 no grant yet", int'(gnt), 4'b0100);
    cyc("R11 other request");
    chk("R11 one cycle later", int'(gnt), 4'b0010);
    idle(3);

    c_mode = 2'b00; c_fp = 0; req_pct = 30; rand_phase("R7/R9", 1500);
    c_mode = 2'b01; c_fp = 1; c_prio = 8'b01_11_01_10; req_pct = 45; rand_phase("R8/R10", 1500);
    c_mode = 2'b10; c_idx = 2'd1; c_fp = 0; c_lim = 6'd4; req_pct = 35; rand_phase("R6/R11", 1500);
    c_mode = 2'b11; c_fp = 1; c_prio = 8'b10_10_00_10; c_lim = 6'd2; req_pct = 55; rand_phase("R6/R8", 1500);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule